// File: doc/BRIEF.md
# Two-wire slave command sequencer

This block is the bus-facing front end of a quad wiper register bank. It watches an open-drain two-wire bus from the system clock domain. Each bus line passes through a two-flop synchronizer and a glitch filter. The block then detects start and stop conditions and checks an 8-bit slave address against four strap pins. It pulls the data line low to acknowledge, and it decodes a command byte. From the command it runs one of three transaction shapes: a bare command that commits at stop, a command with one data byte (read or write), or an open-ended stepping stream in which each bus clock pulse moves a wiper up or down.

Work reaches the register bank as single-cycle operation pulses. Each pulse carries the 4-bit opcode, the channel, the register index, the data byte and a step direction. Writes and transfers are committed only at the stop condition that closes a complete command, so an interrupted command leaves no trace. Reads are issued during the command acknowledge, and the returned byte is shifted out MSB first. The bank reports a busy nonvolatile write through an input. While that input is high the slave does not acknowledge its address, so a master can poll for completion.

Top module: `tw_slave_seq`

## Requirements
- R1: After synchronization, a pulse on SCL or SDA that lasts fewer than FILT_LEN system clocks is ignored and does not disturb a transaction in progress.
- R2: SDA falling while SCL is high is a start. From any state, a start returns the slave to receiving an address. SDA rising while SCL is high is a stop, and it returns the slave to idle.
- R3: The slave acknowledges an address byte whose bits [7:4] are 0101 and whose bits [3:0] equal `dev_addr_i`, by pulling SDA low through the ninth clock. On any other address it stays silent for all bytes up to the next start.
- R4: While `nv_busy_i` is high, the slave does not acknowledge even a matching address.
- R5: In the command byte, bits [7:4] are the opcode, bits [3:2] the channel and bits [1:0] the register. The nine opcodes 1001, 1010, 1011, 1100, 1101, 1110, 0001, 1000 and 0010 are acknowledged. Any other opcode is not acknowledged, and the transaction is dropped.
- R6: The write opcodes (1010 wiper, 1100 data register) take one further data byte, which is acknowledged. One operation carrying that byte on `op_data_o` is issued after the stop. `op_data_o` is zero for every other operation.
- R7: The transfer opcodes (1101, 1110, 0001, 1000) take no data byte. One operation is issued after the stop.
- R8: For the read opcodes (1001, 1011), one operation is issued during the command acknowledge. `rd_data_i` is captured at the end of that acknowledge clock and is driven out MSB first. SDA is released for the master's ninth clock.
- R9: After an acknowledged 0010 command, each complete SCL pulse issues one step operation (opcode 0010) on the SCL falling edge. `op_up_o` equals the SDA level sampled at the rising edge. A pulse cut short by the stop issues nothing.
- R10: A start that arrives before the stop discards a pending write or transfer, and no operation is issued for it.
- R11: The slave only begins pulling SDA low while SCL is low.
- R12: After reset, SDA is released and no operation is signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| sda_pull_o | output | 1 | 1 pulls the data line low, 0 releases it |
| dev_addr_i | input | 4 | Strap value for the low address nibble |
| nv_busy_i | input | 1 | Register bank is busy with a nonvolatile write |
| rd_data_i | input | 8 | Read data returned by the bank after a read operation |
| op_valid_o | output | 1 | One-cycle operation strobe |
| op_kind_o | output | 4 | Opcode of the operation |
| op_chan_o | output | 2 | Channel select |
| op_reg_o | output | 2 | Data register select |
| op_data_o | output | 8 | Write data (zero for other operations) |
| op_up_o | output | 1 | Step direction: 1 up, 0 down |

## Verification
The bench covers several corner cases, each tied to a specific failure:
- **Repeated start after a fully acknowledged write.** A design that committed on the last acknowledge instead of at the stop would issue a stray write.
- **Stop that closes a stepping stream.** The stop's own SCL rise samples SDA low, so a design that stepped on the rising edge would add a spurious decrement.
- **Polling while the bank is busy, then idle.** A design that ignored the busy input would acknowledge too early.
- **Unknown opcode and foreign address.** A design that acknowledged these would hold SDA low on a bus that belongs to another device.
- **A two-clock dip on SCL inside an address bit.** A design without filtering would count an extra bit, misalign the byte and lose the acknowledge.

// File: rtl/twseq_pkg.sv
package twseq_pkg;

  localparam logic [3:0] DEV_TYPE     = 4'b0101;
  localparam logic [3:0] OPC_RD_WIPER = 4'b1001;
  localparam logic [3:0] OPC_WR_WIPER = 4'b1010;
  localparam logic [3:0] OPC_RD_REG   = 4'b1011;
  localparam logic [3:0] OPC_WR_REG   = 4'b1100;
  localparam logic [3:0] OPC_REG2WIP  = 4'b1101;
  localparam logic [3:0] OPC_WIP2REG  = 4'b1110;
  localparam logic [3:0] OPC_G_REG2W  = 4'b0001;
  localparam logic [3:0] OPC_G_W2REG  = 4'b1000;
  localparam logic [3:0] OPC_STEP     = 4'b0010;

  typedef enum logic [2:0] {
    CLS_BAD, CLS_XFER, CLS_READ, CLS_WRITE, CLS_STEP
  } cmd_cls_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_CMD, ST_WDATA, ST_RDATA, ST_HOLD, ST_STEP
  } seq_st_e;

  // Shape of the transaction that follows a command opcode.
  function automatic cmd_cls_e classify(input logic [3:0] opc);
    case (opc)
      OPC_RD_WIPER, OPC_RD_REG:                          return CLS_READ;
      OPC_WR_WIPER, OPC_WR_REG:                          return CLS_WRITE;
      OPC_REG2WIP, OPC_WIP2REG, OPC_G_REG2W, OPC_G_W2REG: return CLS_XFER;
      OPC_STEP:                                          return CLS_STEP;
      default:                                           return CLS_BAD;
    endcase
  endfunction

  // Address byte matches the fixed type nibble and the strap pins.
  function automatic logic addr_hit(input logic [7:0] b, input logic [3:0] pins);
    return (b[7:4] == DEV_TYPE) && (b[3:0] == pins);
  endfunction

endpackage

// File: rtl/tw_line_filter.sv
module tw_line_filter #(
  parameter int  FILT_LEN  = 4,
  parameter bit  RESET_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = (FILT_LEN > 2) ? $clog2(FILT_LEN) : 1;

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;
  logic          lvl_q, rise_q, fall_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= {2{RESET_LVL}};
      cnt_q  <= '0;
      lvl_q  <= RESET_LVL;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], line_i};
      rise_q <= 1'b0;
      fall_q <= 1'b0;
      if (sync_q[1] == lvl_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(FILT_LEN - 1)) begin
        cnt_q  <= '0;
        lvl_q  <= sync_q[1];
        rise_q <= sync_q[1];
        fall_q <= !sync_q[1];
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign lvl_o  = lvl_q;
  assign rise_o = rise_q;
  assign fall_o = fall_q;

  // R1: the filtered level only moves to a value the synchronizer has held
  p_filt_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q != $past(lvl_q)) |-> ($past(sync_q[1]) == lvl_q) && ($past(sync_q[1], 2) == lvl_q));

endmodule

// File: rtl/tw_cond_detect.sv
module tw_cond_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_lvl_i,
  input  logic scl_rise_i,
  input  logic scl_fall_i,
  input  logic sda_lvl_i,
  input  logic sda_rise_i,
  input  logic sda_fall_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_lvl_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic sda_lvl_o
);
  // Bus conditions and clock edges, re-timed together so the sequencer
  // sees them on one common cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_o    <= 1'b0;
      stop_o     <= 1'b0;
      scl_lvl_o  <= 1'b1;
      scl_rise_o <= 1'b0;
      scl_fall_o <= 1'b0;
      sda_lvl_o  <= 1'b1;
    end else begin
      start_o    <= scl_lvl_i && sda_fall_i;
      stop_o     <= scl_lvl_i && sda_rise_i;
      scl_lvl_o  <= scl_lvl_i;
      scl_rise_o <= scl_rise_i;
      scl_fall_o <= scl_fall_i;
      sda_lvl_o  <= sda_lvl_i;
    end
  end
endmodule

// File: rtl/tw_cmd_seq.sv
module tw_cmd_seq
  import twseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       scl_lvl_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       sda_lvl_i,
  input  logic [3:0] dev_addr_i,
  input  logic       nv_busy_i,
  input  logic [7:0] rd_data_i,
  output logic       sda_pull_o,
  output logic       op_valid_o,
  output logic [3:0] op_kind_o,
  output logic [1:0] op_chan_o,
  output logic [1:0] op_reg_o,
  output logic [7:0] op_data_o,
  output logic       op_up_o
);
  seq_st_e    st_q;
  logic [3:0] bit_q;
  logic [7:0] sh_q, wdat_q;
  logic [3:0] opc_q;
  logic [1:0] chan_q, reg_q;
  logic       pull_q, pend_q, dir_q, armed_q;
  logic       opv_q, opu_q;
  logic [3:0] opk_q;
  logic [1:0] opc2_q, opr_q;
  logic [7:0] opd_q;

  // Named internal events
  logic     byte_done, ack_end, addr_decide, cmd_decide, addr_ok;
  cmd_cls_e cls_new, cls_cur;

  assign byte_done   = scl_fall_i && (bit_q == 4'd8);
  assign ack_end     = scl_fall_i && (bit_q == 4'd9);
  assign addr_decide = byte_done && (st_q == ST_ADDR);
  assign cmd_decide  = byte_done && (st_q == ST_CMD);
  assign addr_ok     = addr_hit(sh_q, dev_addr_i) && !nv_busy_i;
  assign cls_new     = classify(sh_q[7:4]);
  assign cls_cur     = classify(opc_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;  bit_q <= '0;  sh_q <= '0;  wdat_q <= '0;
      opc_q <= '0;  chan_q <= '0;  reg_q <= '0;
      pull_q <= 1'b0;  pend_q <= 1'b0;  dir_q <= 1'b0;  armed_q <= 1'b0;
      opv_q <= 1'b0;  opk_q <= '0;  opc2_q <= '0;  opr_q <= '0;
      opd_q <= '0;  opu_q <= 1'b0;
    end else begin
      opv_q <= 1'b0;  opk_q <= '0;  opc2_q <= '0;  opr_q <= '0;
      opd_q <= '0;  opu_q <= 1'b0;
      if (start_i) begin
        st_q <= ST_ADDR;  bit_q <= '0;  pull_q <= 1'b0;
        pend_q <= 1'b0;  armed_q <= 1'b0;
      end else if (stop_i) begin
        if (st_q == ST_HOLD && pend_q) begin
          opv_q  <= 1'b1;  opk_q <= opc_q;  opc2_q <= chan_q;  opr_q <= reg_q;
          opd_q  <= (cls_cur == CLS_WRITE) ? wdat_q : 8'h00;
        end
        st_q <= ST_IDLE;  pull_q <= 1'b0;  pend_q <= 1'b0;  armed_q <= 1'b0;
      end else if (scl_rise_i) begin
        case (st_q)
          ST_ADDR, ST_CMD, ST_WDATA: begin
            if (bit_q < 4'd8) begin
              sh_q  <= {sh_q[6:0], sda_lvl_i};
              bit_q <= bit_q + 4'd1;
            end else if (bit_q == 4'd8) begin
              bit_q <= 4'd9;
            end
          end
          ST_RDATA: if (bit_q != 4'd9) bit_q <= bit_q + 4'd1;
          ST_STEP: begin
            dir_q   <= sda_lvl_i;
            armed_q <= 1'b1;
          end
          default: ;
        endcase
      end else if (scl_fall_i) begin
        case (st_q)
          ST_ADDR: begin
            if (bit_q == 4'd8) begin
              if (addr_ok) pull_q <= 1'b1;
              else         st_q   <= ST_IDLE;
            end else if (bit_q == 4'd9) begin
              pull_q <= 1'b0;  bit_q <= '0;  st_q <= ST_CMD;
            end
          end
          ST_CMD: begin
            if (bit_q == 4'd8) begin
              if (cls_new != CLS_BAD) begin
                pull_q <= 1'b1;
                opc_q  <= sh_q[7:4];  chan_q <= sh_q[3:2];  reg_q <= sh_q[1:0];
                if (cls_new == CLS_READ) begin
                  opv_q <= 1'b1;  opk_q <= sh_q[7:4];
                  opc2_q <= sh_q[3:2];  opr_q <= sh_q[1:0];
                end
              end else begin
                st_q <= ST_IDLE;
              end
            end else if (bit_q == 4'd9) begin
              pull_q <= 1'b0;  bit_q <= '0;
              case (cls_cur)
                CLS_XFER:  begin st_q <= ST_HOLD; pend_q <= 1'b1; end
                CLS_READ:  begin
                  st_q <= ST_RDATA;  sh_q <= rd_data_i;  pull_q <= !rd_data_i[7];
                end
                CLS_WRITE: st_q <= ST_WDATA;
                CLS_STEP:  st_q <= ST_STEP;
                default:   st_q <= ST_IDLE;
              endcase
            end
          end
          ST_WDATA: begin
            if (bit_q == 4'd8) begin
              pull_q <= 1'b1;  wdat_q <= sh_q;
            end else if (bit_q == 4'd9) begin
              pull_q <= 1'b0;  bit_q <= '0;  st_q <= ST_HOLD;  pend_q <= 1'b1;
            end
          end
          ST_RDATA: begin
            if (bit_q >= 4'd1 && bit_q <= 4'd7) begin
              sh_q   <= {sh_q[6:0], 1'b0};
              pull_q <= !sh_q[6];
            end else if (bit_q == 4'd8) begin
              pull_q <= 1'b0;
            end else if (bit_q == 4'd9) begin
              bit_q <= '0;  st_q <= ST_HOLD;
            end
          end
          ST_STEP: begin
            if (armed_q) begin
              opv_q <= 1'b1;  opk_q <= opc_q;  opc2_q <= chan_q;  opr_q <= reg_q;
              opu_q <= dir_q;  armed_q <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_pull_o = pull_q;
  assign op_valid_o = opv_q;
  assign op_kind_o  = opk_q;
  assign op_chan_o  = opc2_q;
  assign op_reg_o   = opr_q;
  assign op_data_o  = opd_q;
  assign op_up_o    = opu_q;

  // R11: SDA is only ever taken low while SCL is low
  p_pull_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> !scl_lvl_i);

  // R4: a busy bank keeps the address unacknowledged
  p_busy_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_decide && nv_busy_i) |=> !sda_pull_o);

  // R5: an unknown opcode is not acknowledged and drops the transaction
  p_bad_cmd_nack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_decide && cls_new == CLS_BAD) |=> (!sda_pull_o && st_q == ST_IDLE));

  // R6: operations only follow a stop or an SCL falling edge
  p_op_after_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid_o |-> $past(stop_i || scl_fall_i));

  // R9: stepping mode only emits step operations
  p_step_kind_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid_o && st_q == ST_STEP) |-> (op_kind_o == OPC_STEP));

  // R10: a start never produces an operation
  p_abort_no_op_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start_i) |-> !op_valid_o);

endmodule

// File: rtl/tw_slave_seq.sv
module tw_slave_seq #(
  parameter int FILT_LEN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  input  logic [3:0] dev_addr_i,
  input  logic       nv_busy_i,
  input  logic [7:0] rd_data_i,
  output logic       op_valid_o,
  output logic [3:0] op_kind_o,
  output logic [1:0] op_chan_o,
  output logic [1:0] op_reg_o,
  output logic [7:0] op_data_o,
  output logic       op_up_o
);
  localparam int NLINES = 2;   // index 0: SCL, index 1: SDA

  logic [NLINES-1:0] raw, lvl, rise, fall;
  logic start, stop, scl_l, scl_r, scl_f, sda_l;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    tw_line_filter #(.FILT_LEN(FILT_LEN), .RESET_LVL(1'b1)) u_filt (
      .clk(clk), .rst_n(rst_n), .line_i(raw[g]),
      .lvl_o(lvl[g]), .rise_o(rise[g]), .fall_o(fall[g])
    );
  end

  tw_cond_detect u_cond (
    .clk(clk), .rst_n(rst_n),
    .scl_lvl_i(lvl[0]), .scl_rise_i(rise[0]), .scl_fall_i(fall[0]),
    .sda_lvl_i(lvl[1]), .sda_rise_i(rise[1]), .sda_fall_i(fall[1]),
    .start_o(start), .stop_o(stop),
    .scl_lvl_o(scl_l), .scl_rise_o(scl_r), .scl_fall_o(scl_f), .sda_lvl_o(sda_l)
  );

  tw_cmd_seq u_seq (
    .clk(clk), .rst_n(rst_n),
    .start_i(start), .stop_i(stop),
    .scl_lvl_i(scl_l), .scl_rise_i(scl_r), .scl_fall_i(scl_f), .sda_lvl_i(sda_l),
    .dev_addr_i(dev_addr_i), .nv_busy_i(nv_busy_i), .rd_data_i(rd_data_i),
    .sda_pull_o(sda_pull_o), .op_valid_o(op_valid_o), .op_kind_o(op_kind_o),
    .op_chan_o(op_chan_o), .op_reg_o(op_reg_o), .op_data_o(op_data_o),
    .op_up_o(op_up_o)
  );

  // R12: nothing is driven straight out of reset
  p_reset_quiet_r12: assert property (@(posedge clk)
    !rst_n |=> (!sda_pull_o && !op_valid_o));

endmodule

// File: tb/tb_tw_slave_seq.sv
module tb_tw_slave_seq;
  localparam int Q = 16;
  localparam logic [3:0] PINS = 4'b1011;
  localparam logic [7:0] MYADDR = {4'b0101, PINS};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic nv_busy = 1'b0;
  logic [7:0] rd_data = 8'h00;
  logic sda_pull, op_valid, op_up;
  logic [3:0] op_kind;
  logic [1:0] op_chan, op_reg;
  logic [7:0] op_data;
  logic sda_line;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [16:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;
  assign sda_line = sda_m & ~sda_pull;

  tw_slave_seq dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .dev_addr_i(PINS), .nv_busy_i(nv_busy),
    .rd_data_i(rd_data), .op_valid_o(op_valid), .op_kind_o(op_kind),
    .op_chan_o(op_chan), .op_reg_o(op_reg), .op_data_o(op_data), .op_up_o(op_up)
  );

  function automatic logic [7:0] bank_val(input logic [3:0] k, input logic [1:0] c,
                                          input logic [1:0] r);
    return (k == 4'b1001) ? (8'h96 ^ {c, c, c, c}) : (8'h3C ^ {c, r, c, r});
  endfunction

  // Bank model: answers read operations one cycle later
  always @(posedge clk)
    if (op_valid && (op_kind == 4'b1001 || op_kind == 4'b1011))
      rd_data <= bank_val(op_kind, op_chan, op_reg);

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_op(input logic [3:0] k, input logic [1:0] c, input logic [1:0] r,
                           input logic [7:0] d, input logic u, input string req);
    exp_q.push_back({k, c, r, d, u});
    tag_q.push_back(req);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && op_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10 unexpected operation", {15'd0, op_kind, op_chan, op_reg, op_data, op_up}, 0);
      end else begin
        logic [16:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({op_kind, op_chan, op_reg, op_data, op_up} == e, t,
            {15'd0, op_kind, op_chan, op_reg, op_data, op_up}, {15'd0, e});
      end
    end
  end

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    if (scl_m == 1'b0) begin
      sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
    end
    sda_m = 1'b0; wq(2*Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(2*Q);
  endtask

  task automatic send_bit(input logic b, input bit glitch);
    sda_m = b; wq(Q); scl_m = 1'b1;
    if (glitch) begin
      wq(Q); scl_m = 1'b0; wq(2); scl_m = 1'b1; wq(Q - 2);
    end else wq(2*Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, input bit glitch, output bit ack,
                           output bit pre);
    for (int i = 7; i >= 0; i--) send_bit(v[i], glitch && (i == 5));
    sda_m = 1'b1; wq(Q); pre = sda_pull;
    scl_m = 1'b1; wq(Q); ack = !sda_line; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic read_byte(output logic [7:0] v);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(Q); scl_m = 1'b1; wq(Q); v[i] = sda_line; wq(Q); scl_m = 1'b0; wq(Q);
    end
    send_bit(1'b1, 1'b0);
  endtask

  task automatic step_pulse(input logic up);
    sda_m = up; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    bit a, p;
    logic [7:0] v;
    wq(10);
    rst_n = 1'b1;
    wq(4);
    chk(!sda_pull && !op_valid, "R12 reset quiet", {sda_pull, op_valid}, 0);

    // R6 write wiper; R3 address ack; R5 command ack; R11 pull set with SCL low
    expect_op(4'b1010, 2'd2, 2'd0, 8'h3F, 1'b0, "R6 write wiper op");
    bus_start();
    send_byte(MYADDR, 1'b0, a, p);
    chk(a, "R3 address ack", a, 1);
    chk(p, "R11 pull active before ack clock rises", p, 1);
    send_byte({4'b1010, 2'd2, 2'd0}, 1'b0, a, p);
    chk(a, "R5 write-wiper command ack", a, 1);
    send_byte(8'h3F, 1'b0, a, p);
    chk(a, "R6 data byte ack", a, 1);
    bus_stop(); wq(40);

    // R6 write data register
    expect_op(4'b1100, 2'd1, 2'd3, 8'hC3, 1'b0, "R6 write register op");
    bus_start();
    send_byte(MYADDR, 1'b0, a, p);
    send_byte({4'b1100, 2'd1, 2'd3}, 1'b0, a, p);
    send_byte(8'hC3, 1'b0, a, p);
    chk(a, "R6 register data ack", a, 1);
    bus_stop(); wq(40);

    // R7 transfers, local and global
    expect_op(4'b1101, 2'd3, 2'd2, 8'h00, 1'b0, "R7 register-to-wiper op");
    bus_start();
    send_byte(MYADDR, 1'b0, a, p);
    send_byte({4'b1101, 2'd3, 2'd2}, 1'b0, a, p);
    chk(a, "R7 transfer command ack", a, 1);
    bus_stop(); wq(40);
    expect_op(4'b1000, 2'd0, 2'd1, 8'h00, 1'b0, "R7 global wiper-to-register op");
    bus_start();
    send_byte(MYADDR, 1'b0, a, p);
    send_byte({4'b1000, 2'd0, 2'd1}, 1'b0, a, p);
    bus_stop(); wq(40);

    // R8 reads
    expect_op(4'b1001, 2'd1, 2'd0, 8'h00, 1'b0, "R8 read wiper op");
    bus_start();
    send_byte(MYADDR, 1'b0, a, p);
    send_byte({4'b1001, 2'd1, 2'd0}, 1'b0, a, p);
    read_byte(v);
    chk(v == bank_val(4'b1001, 2'd1, 2'd0), "R8 read wiper byte", v, bank_val(4'b1001, 2'd1, 2'd0));
    bus_stop(); wq(40);
    expect_op(4'b1011, 2'd0, 2'd2, 8'h00, 1'b0, "R8 read register op");
    bus_start();
    send_byte(MYADDR, 1'b0, a, p);
    send_byte({4'b1011, 2'd0, 2'd2}, 1'b0, a, p);
    read_byte(v);
    chk(v == bank_val(4'b1011, 2'd0, 2'd2), "R8 read register byte", v, bank_val(4'b1011, 2'd0, 2'd2));
    bus_stop(); wq(40);

    // R3 foreign address: silent for all bytes
    bus_start();
    send_byte(8'h5A, 1'b0, a, p);
    chk(!a, "R3 foreign address not acked", a, 0);
    send_byte({4'b1010, 2'd0, 2'd0}, 1'b0, a, p);
    chk(!a, "R3 silent after foreign address", a, 0);
    bus_stop(); wq(40);

    // R4 busy polling
    nv_busy = 1'b1;
    bus_start();
    send_byte(MYADDR, 1'b0, a, p);
    chk(!a, "R4 no ack while busy", a, 0);
    bus_stop(); wq(40);
    nv_busy = 1'b0;
    expect_op(4'b1110, 2'd0, 2'd0, 8'h00, 1'b0, "R4 op after busy clears");
    bus_start();
    send_byte(MYADDR, 1'b0, a, p);
    chk(a, "R4 ack once idle", a, 1);
    send_byte({4'b1110, 2'd0, 2'd0}, 1'b0, a, p);
    bus_stop(); wq(40);

    // R5 unknown opcodes
    bus_start();
    send_byte(MYADDR, 1'b0, a, p);
    send_byte({4'b0000, 2'd1, 2'd1}, 1'b0, a, p);
    chk(!a, "R5 opcode 0000 not acked", a, 0);
    bus_stop(); wq(40);
    bus_start();
    send_byte(MYADDR, 1'b0, a, p);
    send_byte({4'b1111, 2'd1, 2'd1}, 1'b0, a, p);
    chk(!a, "R5 opcode 1111 not acked", a, 0);
    bus_stop(); wq(40);

    // R9 stepping stream
    bus_start();
    send_byte(MYADDR, 1'b0, a, p);
    send_byte({4'b0010, 2'd2, 2'd0}, 1'b0, a, p);
    chk(a, "R9 step command ack", a, 1);
    expect_op(4'b0010, 2'd2, 2'd0, 8'h00, 1'b1, "R9 step up 1");
    step_pulse(1'b1);
    expect_op(4'b0010, 2'd2, 2'd0, 8'h00, 1'b1, "R9 step up 2");
    step_pulse(1'b1);
    expect_op(4'b0010, 2'd2, 2'd0, 8'h00, 1'b0, "R9 step down");
    step_pulse(1'b0);
    bus_stop(); wq(40);
    chk(exp_q.size() == 0, "R9 stop adds no step", exp_q.size(), 0);

    // R10 repeated start discards pending write
    bus_start();
    send_byte(MYADDR, 1'b0, a, p);
    send_byte({4'b1010, 2'd3, 2'd0}, 1'b0, a, p);
    send_byte(8'h11, 1'b0, a, p);
    chk(a, "R10 write acked before abort", a, 1);
    expect_op(4'b1101, 2'd0, 2'd1, 8'h00, 1'b0, "R10 only the new transfer issues");
    bus_start();
    send_byte(MYADDR, 1'b0, a, p);
    chk(a, "R2 repeated start restarts address phase", a, 1);
    send_byte({4'b1101, 2'd0, 2'd1}, 1'b0, a, p);
    bus_stop(); wq(40);

    // R1 short SCL dip during address
    expect_op(4'b0001, 2'd0, 2'd2, 8'h00, 1'b0, "R1 op after glitched address");
    bus_start();
    send_byte(MYADDR, 1'b1, a, p);
    chk(a, "R1 glitch ignored, address acked", a, 1);
    send_byte({4'b0001, 2'd0, 2'd2}, 1'b0, a, p);
    bus_stop(); wq(60);

    chk(exp_q.size() == 0, "R7 all expected ops issued", exp_q.size(), 0);
    finish_run();
  end
endmodule